// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This unit computes the extended bit-manipulation results of a 32-bit load/store core's integer pipe. It covers leading-zero and leading-one counts, byte and halfword sign extension, full bit reversal, byte swaps inside each halfword and across the word, bit-field extract and insert, and logical right shifts that turn into rotates when a spare encoding field holds 1. Decode has already split the instruction word into an operation select, two register operands, a position field, a size/msb field, a modifier field and a destination index. This unit returns one registered result per issued operation, one cycle later.

A write-enable goes with each result. It stays low when the destination is register 0 and when the operation is illegal. An unknown select, a shift with a modifier above 1, or an insert whose msb lies below its position raises a one-cycle illegal flag instead of a write. The register file and instruction decode are outside the block.

Top module: `bitmanip_unit`

## Requirements
- R1: Select 0 returns the number of leading zero bits of `src_a_i`, and select 1 the number of leading one bits. An all-zero operand to select 0 and an all-ones operand to select 1 both give 32.
- R2: Select 2 returns `src_b_i[7:0]` with bit 7 copied into bits 31..8. Select 3 returns `src_b_i[15:0]` with bit 15 copied into bits 31..16.
- R3: Select 4 returns `src_b_i` with bit i moved to bit 31-i.
- R4: Select 5 exchanges the two bytes inside each 16-bit half of `src_b_i`. Select 6 returns the four bytes of `src_b_i` in reverse order.
- R5: Select 7 (extract) returns `size_i+1` bits of `src_a_i` taken from bit `pos_i` upward, right-justified, with zeros above them.
- R6: Select 8 (insert) returns `src_b_i` with bits `pos_i` through `size_i` replaced by the low `size_i+1-pos_i` bits of `src_a_i`. All other bits keep their old value.
- R7: Select 9 shifts `src_b_i` right by `pos_i`. With `mod_i`=0 the shift is logical, with `mod_i`=1 it is a rotate, and any other `mod_i` value is illegal.
- R8: Select 10 shifts `src_b_i` right by `src_a_i[4:0]`; the upper bits of `src_a_i` are ignored. With `mod_i`=0 the shift is logical, with `mod_i`=1 it is a rotate, and any other `mod_i` value is illegal.
- R9: A legal operation with `dst_i`=0 leaves `wr_en_o` low. A legal operation with any other `dst_i` drives `wr_en_o` high.
- R10: Selects 11 to 15, and an insert with `size_i` < `pos_i`, are illegal. An illegal operation drives `illegal_o` high for one cycle, keeps `wr_en_o` low and sets `result_o` to 0.
- R11: The outputs of an operation issued at a clock edge appear after that edge. A cycle without `issue_i` drives `wr_en_o` and `illegal_o` low and holds `result_o`.
- R12: While `rst_n` is low at a clock edge, all outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation select (see R1 to R10) |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand; old destination value for insert |
| pos_i | input | 5 | Bit position or immediate shift amount |
| size_i | input | 5 | Extract size minus one, or insert msb |
| mod_i | input | 5 | Spare encoding field that picks shift or rotate |
| dst_i | input | 5 | Destination register index |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Result is to be written |
| illegal_o | output | 1 | Issued operation was illegal |

## Verification
On every cycle the assertions check the following: register 0 is never written; an illegal flag never comes with a write or a nonzero result; idle cycles keep the outputs quiet and the result stable; a zero operand counts to 32; a rotate keeps the operand's population count; an extract leaves zeros above its field. The exact bit values need the bench's reference functions over directed and random operands. These include the placement of an inserted field, the byte orders of the swaps, rotate-versus-shift selection by `mod_i`, and masking of the variable amount.

// File: rtl/bitmanip_pkg.sv
// Shared definitions for the bit manipulation unit.
// Assumes: operation selects are the fixed 4-bit codes below; other codes are illegal.
package bitmanip_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_CLZ   = 4'd0;
    localparam logic [OP_W-1:0] OP_CLO   = 4'd1;
    localparam logic [OP_W-1:0] OP_SEB   = 4'd2;
    localparam logic [OP_W-1:0] OP_SEH   = 4'd3;
    localparam logic [OP_W-1:0] OP_BREV  = 4'd4;
    localparam logic [OP_W-1:0] OP_SWPH  = 4'd5;
    localparam logic [OP_W-1:0] OP_SWPW  = 4'd6;
    localparam logic [OP_W-1:0] OP_EXT   = 4'd7;
    localparam logic [OP_W-1:0] OP_INS   = 4'd8;
    localparam logic [OP_W-1:0] OP_SHRI  = 4'd9;
    localparam logic [OP_W-1:0] OP_SHRV  = 4'd10;

    // modifier field values for the right-shift selects
    localparam int MOD_LOGICAL = 0;
    localparam int MOD_ROTATE  = 1;
endpackage

// File: rtl/bm_lead_count.sv
// Leading-bit counter.
// Counts leading zeros of the operand, or leading ones when invert_i is set.
// Assumes: DATA_W >= 2. Purely combinational.
module bm_lead_count #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic              invert_i,
    output logic [CNT_W-1:0]  count_o
);
    logic [DATA_W-1:0] scan;

    // pick the polarity to scan
    assign scan = invert_i ? ~operand_i : operand_i;

    // the highest set bit fixes the count; no set bit gives DATA_W
    always_comb begin
        count_o = CNT_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (scan[i]) count_o = CNT_W'(DATA_W - 1 - i);
        end
    end
endmodule

// File: rtl/bm_permute.sv
// Fixed bit permutations: byte/halfword sign extension, bit reversal,
// byte swap inside halfwords and across the word.
// Assumes: DATA_W is a multiple of 16. Purely combinational.
module bm_permute
    import bitmanip_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NBYTE = DATA_W / 8
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] result_o
);
    logic [DATA_W-1:0] rev_bits;
    logic [DATA_W-1:0] swap_half;
    logic [DATA_W-1:0] swap_word;

    // bit i goes to the mirrored position
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_bits[i] = operand_i[DATA_W-1-i];
    end

    // byte lanes: pairwise exchange and full reversal
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign swap_half[8*b +: 8] = operand_i[8*(b ^ 1) +: 8];
        assign swap_word[8*b +: 8] = operand_i[8*(NBYTE-1-b) +: 8];
    end

    // choose the permutation for this select
    always_comb begin
        unique case (op_i)
            OP_SEB:  result_o = {{(DATA_W-8){operand_i[7]}}, operand_i[7:0]};
            OP_SEH:  result_o = {{(DATA_W-16){operand_i[15]}}, operand_i[15:0]};
            OP_BREV: result_o = rev_bits;
            OP_SWPH: result_o = swap_half;
            default: result_o = swap_word;
        endcase
    end
endmodule

// File: rtl/bm_field.sv
// Bit-field extract and insert.
// Extract: (size+1) bits from pos upward, right-justified, zero filled.
// Insert: bits pos..msb of the old value replaced by the low bits of the source.
// Assumes: field_bad_o flags an insert whose msb is below its position.
module bm_field #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [SH_W-1:0]   pos_i,
    input  logic [SH_W-1:0]   size_i,
    input  logic              insert_i,
    output logic [DATA_W-1:0] result_o,
    output logic              field_bad_o
);
    logic [SH_W:0]     span;
    logic [DATA_W-1:0] span_ones;
    logic [DATA_W-1:0] pos_ones;
    logic [DATA_W-1:0] ins_mask;

    // size/msb field plus one, one bit wider so that DATA_W fits
    assign span = {1'b0, size_i} + 1'b1;

    // thermometer masks: ones below span and below pos
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            span_ones[i] = (i < int'(span));
            pos_ones[i]  = (i < int'(pos_i));
        end
    end

    assign ins_mask    = span_ones & ~pos_ones;
    assign field_bad_o = insert_i && (size_i < pos_i);

    // merge for insert, shift and mask for extract
    always_comb begin
        if (insert_i) result_o = (old_i & ~ins_mask) | ((src_i << pos_i) & ins_mask);
        else          result_o = (src_i >> pos_i) & span_ones;
    end
endmodule

// File: rtl/bm_rotate.sv
// Right shift unit: logical shift, or rotate when rotate_i is set.
// Assumes: the amount is already reduced to log2(DATA_W) bits. Combinational.
module bm_rotate #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [SH_W-1:0]   amount_i,
    input  logic              rotate_i,
    output logic [DATA_W-1:0] result_o
);
    logic [2*DATA_W-1:0] doubled;
    logic [2*DATA_W-1:0] shifted;

    // upper copy supplies the wrapped bits for a rotate
    assign doubled  = {rotate_i ? operand_i : {DATA_W{1'b0}}, operand_i};
    assign shifted  = doubled >> amount_i;
    assign result_o = shifted[DATA_W-1:0];
endmodule

// File: rtl/bitmanip_unit.sv
// Bit manipulation execution unit, one registered cycle of latency.
// Selects a result among count, permute, field and shift/rotate datapaths,
// checks legality, and suppresses writes to register 0.
// Assumes: decode supplies split fields; the register file lives elsewhere.
module bitmanip_unit
    import bitmanip_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [SH_W-1:0]   pos_i,
    input  logic [SH_W-1:0]   size_i,
    input  logic [SH_W-1:0]   mod_i,
    input  logic [REG_AW-1:0] dst_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              illegal_o
);
    logic [CNT_W-1:0]  lead_cnt;
    logic [DATA_W-1:0] perm_res;
    logic [DATA_W-1:0] field_res;
    logic              field_bad;
    logic [DATA_W-1:0] shr_res;
    logic [SH_W-1:0]   shr_amt;
    logic              shr_rot;
    logic              is_ins;
    logic              is_clo;
    logic [DATA_W-1:0] next_res;
    logic              legal;

    assign is_ins  = (op_i == OP_INS);
    assign is_clo  = (op_i == OP_CLO);
    // variable shift takes only the low amount bits of src_a
    assign shr_amt = (op_i == OP_SHRV) ? src_a_i[SH_W-1:0] : pos_i;
    assign shr_rot = (mod_i == SH_W'(MOD_ROTATE));

    bm_lead_count #(.DATA_W(DATA_W)) u_count (
        .operand_i (src_a_i),
        .invert_i  (is_clo),
        .count_o   (lead_cnt)
    );

    bm_permute #(.DATA_W(DATA_W)) u_permute (
        .op_i      (op_i),
        .operand_i (src_b_i),
        .result_o  (perm_res)
    );

    bm_field #(.DATA_W(DATA_W)) u_field (
        .src_i       (src_a_i),
        .old_i       (src_b_i),
        .pos_i       (pos_i),
        .size_i      (size_i),
        .insert_i    (is_ins),
        .result_o    (field_res),
        .field_bad_o (field_bad)
    );

    bm_rotate #(.DATA_W(DATA_W)) u_rotate (
        .operand_i (src_b_i),
        .amount_i  (shr_amt),
        .rotate_i  (shr_rot),
        .result_o  (shr_res)
    );

    // result mux and legality decision for the presented select
    always_comb begin
        legal    = 1'b1;
        next_res = '0;
        case (op_i)
            OP_CLZ, OP_CLO:
                next_res = {{(DATA_W-CNT_W){1'b0}}, lead_cnt};
            OP_SEB, OP_SEH, OP_BREV, OP_SWPH, OP_SWPW:
                next_res = perm_res;
            OP_EXT:
                next_res = field_res;
            OP_INS: begin
                next_res = field_res;
                legal    = !field_bad;
            end
            OP_SHRI, OP_SHRV: begin
                next_res = shr_res;
                legal    = (mod_i <= SH_W'(MOD_ROTATE));
            end
            default:
                legal = 1'b0;
        endcase
    end

    // output register: capture on issue, quiet flags otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else if (issue_i) begin
            result_o  <= legal ? next_res : '0;
            wr_en_o   <= legal && (dst_i != '0);
            illegal_o <= !legal;
        end else begin
            wr_en_o   <= 1'b0;
            illegal_o <= 1'b0;
        end
    end

    // ---------------- assertions ----------------
    p_zero_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_i == '0 && !is_clo) |-> (lead_cnt == CNT_W'(DATA_W)));

    p_ext_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_EXT) |-> ((field_res >> ({1'b0, size_i} + 1'b1)) == '0));

    p_rot_popcount_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shr_rot |-> ($countones(shr_res) == $countones(src_b_i)));

    p_no_reg0_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && dst_i == '0) |=> !wr_en_o);

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && result_o == '0));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && !illegal_o && $stable(result_o)));
endmodule

// File: tb/bitmanip_unit_bench.sv
`timescale 1ns/1ps
module bitmanip_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  pos = '0;
    logic [4:0]  size = '0;
    logic [4:0]  mod = '0;
    logic [4:0]  dst = '0;
    logic [31:0] result;
    logic        wr_en;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bitmanip_unit u_bitmanip_unit (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_i(op),
        .src_a_i(a), .src_b_i(b), .pos_i(pos), .size_i(size),
        .mod_i(mod), .dst_i(dst),
        .result_o(result), .wr_en_o(wr_en), .illegal_o(illegal)
    );

    // reference: leading run length of value v's bits equal to lvl
    function automatic logic [31:0] ref_lead(input logic [31:0] v, input logic lvl);
        int n = 0;
        while (n < 32 && v[31-n] == lvl) n++;
        return 32'(n);
    endfunction

    function automatic logic ref_legal(input logic [3:0] o, input logic [4:0] p,
                                       input logic [4:0] s, input logic [4:0] m);
        if (o > 4'd10) return 1'b0;
        if (o == 4'd8 && s < p) return 1'b0;
        if ((o == 4'd9 || o == 4'd10) && m > 5'd1) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] ref_result(input logic [3:0] o, input logic [31:0] x,
                                               input logic [31:0] y, input logic [4:0] p,
                                               input logic [4:0] s, input logic [4:0] m);
        logic [63:0] msk;
        logic [63:0] two;
        logic [31:0] r;
        int amt;
        r = '0;
        case (o)
            4'd0: r = ref_lead(x, 1'b0);
            4'd1: r = ref_lead(x, 1'b1);
            4'd2: r = {{24{y[7]}}, y[7:0]};
            4'd3: r = {{16{y[15]}}, y[15:0]};
            4'd4: for (int k = 0; k < 32; k++) r[31-k] = y[k];
            4'd5: r = {y[23:16], y[31:24], y[7:0], y[15:8]};
            4'd6: r = {y[7:0], y[15:8], y[23:16], y[31:24]};
            4'd7: begin
                msk = (64'd1 << (int'(s) + 1)) - 64'd1;
                r = 32'((64'(x) >> p) & msk);
            end
            4'd8: begin
                msk = ((64'd1 << (int'(s) + 1 - int'(p))) - 64'd1) << p;
                r = 32'((64'(y) & ~msk) | ((64'(x) << p) & msk));
            end
            4'd9, 4'd10: begin
                amt = (o == 4'd9) ? int'(p) : int'(x % 32);
                two = (m == 5'd1) ? {y, y} : {32'd0, y};
                r = 32'(two >> amt);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // issue one operation, then compare all outputs one cycle later
    task automatic run_op(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                          input logic [4:0] p, input logic [4:0] s, input logic [4:0] m,
                          input logic [4:0] d, input string req);
        logic lg;
        @(negedge clk);
        op = o; a = x; b = y; pos = p; size = s; mod = m; dst = d; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        lg = ref_legal(o, p, s, m);
        chk(req, "result", result, lg ? ref_result(o, x, y, p, s, m) : 32'd0);
        chk(req, "wr_en", 32'(wr_en), 32'(lg && d != 5'd0));
        chk(req, "illegal", 32'(illegal), 32'(!lg));
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        // R12: reset clears outputs
        repeat (3) @(negedge clk);
        chk("R12", "result", result, 32'd0);
        chk("R12", "wr_en", 32'(wr_en), 32'd0);
        chk("R12", "illegal", 32'(illegal), 32'd0);
        rst_n = 1'b1;

        // R1 counts
        run_op(4'd0, 32'h0000_0000, 0, 0, 0, 0, 5'd3, "R1");
        run_op(4'd0, 32'h0000_0001, 0, 0, 0, 0, 5'd3, "R1");
        run_op(4'd0, 32'h8000_0000, 0, 0, 0, 0, 5'd3, "R1");
        run_op(4'd1, 32'hFFFF_FFFF, 0, 0, 0, 0, 5'd3, "R1");
        run_op(4'd1, 32'hF0F0_0000, 0, 0, 0, 0, 5'd3, "R1");
        // R2 sign extension
        run_op(4'd2, 0, 32'h1234_5680, 0, 0, 0, 5'd4, "R2");
        run_op(4'd2, 0, 32'hFFFF_FF7F, 0, 0, 0, 5'd4, "R2");
        run_op(4'd3, 0, 32'h0000_8001, 0, 0, 0, 5'd4, "R2");
        run_op(4'd3, 0, 32'hFFFF_7FFF, 0, 0, 0, 5'd4, "R2");
        // R3 reversal
        run_op(4'd4, 0, 32'h0000_0001, 0, 0, 0, 5'd5, "R3");
        run_op(4'd4, 0, 32'h1234_5678, 0, 0, 0, 5'd5, "R3");
        // R4 byte swaps
        run_op(4'd5, 0, 32'h1122_3344, 0, 0, 0, 5'd6, "R4");
        run_op(4'd6, 0, 32'h1122_3344, 0, 0, 0, 5'd6, "R4");
        // R5 extract, including full width and top field
        run_op(4'd7, 32'hABCD_1234, 0, 5'd4, 5'd7, 0, 5'd7, "R5");
        run_op(4'd7, 32'hABCD_1234, 0, 5'd0, 5'd31, 0, 5'd7, "R5");
        run_op(4'd7, 32'hABCD_1234, 0, 5'd28, 5'd31, 0, 5'd7, "R5");
        // R6 insert, including a single bit and the full word
        run_op(4'd8, 32'h0000_00AA, 32'hFFFF_FFFF, 5'd8, 5'd15, 0, 5'd8, "R6");
        run_op(4'd8, 32'hFFFF_FFFF, 32'h0000_0000, 5'd31, 5'd31, 0, 5'd8, "R6");
        run_op(4'd8, 32'h1357_9BDF, 32'h2468_ACE0, 5'd0, 5'd31, 0, 5'd8, "R6");
        // R7 immediate shift and rotate
        run_op(4'd9, 0, 32'h1234_5678, 5'd4, 0, 5'd1, 5'd9, "R7");
        run_op(4'd9, 0, 32'h8765_4321, 5'd4, 0, 5'd0, 5'd9, "R7");
        run_op(4'd9, 0, 32'h8765_4321, 5'd0, 0, 5'd1, 5'd9, "R7");
        run_op(4'd9, 0, 32'h8765_4321, 5'd4, 0, 5'd2, 5'd9, "R7");
        // R8 variable amount, upper bits of the amount ignored
        run_op(4'd10, 32'hFFFF_FFE4, 32'h1234_5678, 0, 0, 5'd1, 5'd10, "R8");
        run_op(4'd10, 32'h0000_003F, 32'h8000_0001, 0, 0, 5'd0, 5'd10, "R8");
        run_op(4'd10, 32'h0000_0004, 32'h1234_5678, 0, 0, 5'd3, 5'd10, "R8");
        // R9 destination zero
        run_op(4'd6, 0, 32'hDEAD_BEEF, 0, 0, 0, 5'd0, "R9");
        run_op(4'd0, 32'h0001_0000, 0, 0, 0, 0, 5'd31, "R9");
        // R10 illegal selects and reversed insert field
        run_op(4'd11, 32'h1, 32'h2, 0, 0, 0, 5'd1, "R10");
        run_op(4'd15, 32'h1, 32'h2, 0, 0, 0, 5'd1, "R10");
        run_op(4'd8, 32'hFF, 32'h0, 5'd9, 5'd8, 0, 5'd1, "R10");

        // R11: idle cycle keeps result, no write, no flag
        run_op(4'd6, 0, 32'hCAFE_F00D, 0, 0, 0, 5'd2, "R11");
        held = result;
        @(negedge clk);
        chk("R11", "held result", result, held);
        chk("R11", "idle wr_en", 32'(wr_en), 32'd0);
        chk("R11", "idle illegal", 32'(illegal), 32'd0);

        // random mix across all selects
        for (int n = 0; n < 600; n++) begin
            logic [3:0] o;
            logic [4:0] p;
            logic [4:0] s;
            logic [4:0] m;
            o = 4'($urandom % 13);
            p = 5'($urandom);
            s = 5'($urandom);
            m = 5'($urandom % 3);
            if (o == 4'd8 && s < p && ($urandom % 4) != 0) begin
                logic [4:0] t;
                t = p; p = s; s = t;
            end
            run_op(o, $urandom, $urandom, p, s, m, 5'($urandom), "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule